// File: doc/BRIEF.md
# Whitened Radio Frame Builder

This block assembles one transmit frame for a low-cost 2.4 GHz transceiver and emits it as a byte stream over a valid/ready handshake. A single-cycle start pulse captures an address of three to five bytes and a payload of up to sixteen bytes. The block then sends the following bytes in order:

- a length byte;
- a fixed three-byte preamble;
- the address, whitened;
- the payload, bit-reversed and whitened;
- a 16-bit check value.

Whitening XORs each byte with an entry of a fixed table. The table index runs on without a break from the address section into the payload section.

The check value is a CCITT-polynomial CRC taken over the whitened bytes. It is finished with an XOR constant that depends on the address and payload lengths. Downstream logic pushes the bytes into the radio's transmit buffer. The block applies back-pressure through the ready input and reports a busy flag for the whole frame.

Top module: `frame_builder`

## Requirements
- R1: After reset, out_valid, busy and out_last are 0.
- R2: The captured address length is addr_len_req clamped to 3..5: values 0..2 give 3 and values 6..7 give 5. The captured payload length is pay_len_req clamped to 0..16: values 17..31 give 16.
- R3: Byte 0 of a frame equals A+P+5, where A is the address length and P is the payload length. Bytes 1, 2 and 3 are 0x71, 0x0F and 0x55.
- R4: Address byte k sits at addr_in[8k+7:8k]. The frame sends byte A-1 first and byte 0 last. The byte at body position j (j=0 at frame byte 4) is XORed with W[j], where W is the 24-entry whitening table E3 B1 4B EA 85 BC E5 66 0D AE 8C 88 12 69 EE 1F C7 62 97 D5 0B 79 CA CC.
- R5: Payload byte i sits at pay_in[8i+7:8i]. It is sent bit-reversed (bit 0 becomes bit 7) and then XORed with W[A+i].
- R6: The CRC starts at 0xB5D2. It is updated with polynomial 0x1021, MSB first, with no reflection, over every whitened body byte. When A is 3, body byte 0 is left out.
- R7: The CRC is XORed with the constant {W[k], W[k+1]}, where k = A-3+P. It is sent high byte first, then low byte. out_last is 1 only on the low byte.
- R8: A byte is accepted when out_valid and out_ready are both 1. While out_ready is 0, out_data and out_last hold their values.
- R9: busy rises on the edge that captures start and falls on the edge that accepts the last byte. out_valid equals busy.
- R10: A start pulse while busy is 1 is ignored. Input changes during a frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse; captures the inputs when idle |
| addr_len_req | input | 3 | Requested address length in bytes |
| addr_in | input | 40 | Address bytes, byte 0 in bits 7:0 |
| pay_len_req | input | 5 | Requested payload length in bytes |
| pay_in | input | 128 | Payload bytes, byte 0 in bits 7:0 |
| out_data | output | 8 | Current frame byte |
| out_valid | output | 1 | out_data holds a frame byte |
| out_ready | input | 1 | Sink accepts the byte this cycle |
| out_last | output | 1 | Current byte is the final byte of the frame |
| busy | output | 1 | A frame is in progress |

## Verification
The first frame byte is due one edge after start is sampled. Each later byte is due one edge after its predecessor is accepted, and busy clears one edge after the final acceptance. The bench drives inputs and samples outputs on the falling clock edge. At each falling edge it compares the presented byte with its own frame model, then decides ready for the coming rising edge. A stalled byte is therefore checked again at every stall cycle. The CRC bytes reach the port only after every body byte has been accepted, so the model's CRC is compared at exactly the frame positions A+P+4 and A+P+5.

// File: rtl/fb_pkg.sv
package fb_pkg;
    localparam int ADDR_MIN   = 3;
    localparam int ADDR_MAX   = 5;
    localparam int PAY_MAX    = 16;
    localparam int BYTE_W     = 8;
    localparam int HDR_BYTES  = 4;
    localparam int CRC_BYTES  = 2;
    localparam int ALEN_W     = $clog2(ADDR_MAX + 1);
    localparam int PLEN_W     = $clog2(PAY_MAX + 1);
    localparam int FRAME_MAX  = HDR_BYTES + ADDR_MAX + PAY_MAX + CRC_BYTES;
    localparam int POS_W      = $clog2(FRAME_MAX);
    localparam int ADDR_BITS  = ADDR_MAX * BYTE_W;
    localparam int PAY_BITS   = PAY_MAX * BYTE_W;
    localparam logic [15:0] CRC_SEED = 16'hB5D2;
    localparam logic [15:0] CRC_POLY = 16'h1021;
    localparam logic [7:0]  PRE0 = 8'h71;
    localparam logic [7:0]  PRE1 = 8'h0F;
    localparam logic [7:0]  PRE2 = 8'h55;

    typedef enum logic [2:0] {
        SEG_LEN, SEG_PRE, SEG_ADDR, SEG_PAY, SEG_CRC_HI, SEG_CRC_LO
    } seg_e;

    typedef enum logic {ST_IDLE, ST_SEND} state_e;

    typedef struct packed {
        logic [ALEN_W-1:0]    alen;
        logic [PLEN_W-1:0]    plen;
        logic [ADDR_BITS-1:0] addr;
        logic [PAY_BITS-1:0]  pay;
    } frame_cfg_t;

    function automatic logic [7:0] whiten(input logic [4:0] idx);
        case (idx)
            5'd0:  return 8'hE3;  5'd1:  return 8'hB1;  5'd2:  return 8'h4B;
            5'd3:  return 8'hEA;  5'd4:  return 8'h85;  5'd5:  return 8'hBC;
            5'd6:  return 8'hE5;  5'd7:  return 8'h66;  5'd8:  return 8'h0D;
            5'd9:  return 8'hAE;  5'd10: return 8'h8C;  5'd11: return 8'h88;
            5'd12: return 8'h12;  5'd13: return 8'h69;  5'd14: return 8'hEE;
            5'd15: return 8'h1F;  5'd16: return 8'hC7;  5'd17: return 8'h62;
            5'd18: return 8'h97;  5'd19: return 8'hD5;  5'd20: return 8'h0B;
            5'd21: return 8'h79;  5'd22: return 8'hCA;  5'd23: return 8'hCC;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [15:0] crc_xorout(input logic [4:0] k);
        return {whiten(k), whiten(k + 5'd1)};
    endfunction

    function automatic logic [7:0] bitrev8(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        logic        fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[15] ^ d[i];
            r  = {r[14:0], 1'b0};
            if (fb) r = r ^ CRC_POLY;
        end
        return r;
    endfunction

    function automatic logic [ALEN_W-1:0] clamp_alen(input logic [2:0] req);
        if (req < 3'(ADDR_MIN)) return ALEN_W'(ADDR_MIN);
        if (req > 3'(ADDR_MAX)) return ALEN_W'(ADDR_MAX);
        return ALEN_W'(req);
    endfunction

    function automatic logic [PLEN_W-1:0] clamp_plen(input logic [4:0] req);
        if (req > 5'(PAY_MAX)) return PLEN_W'(PAY_MAX);
        return PLEN_W'(req);
    endfunction
endpackage

// File: rtl/fb_crc.sv
module fb_crc
    import fb_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [15:0] crc
);
    always_ff @(posedge clk) begin
        if (rst || clr) crc <= CRC_SEED;
        else if (en)    crc <= crc_step(crc, din);
    end

    p_crc_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !en) |=> $stable(crc));
    p_crc_seed_r6: assert property (@(posedge clk) disable iff (rst)
        clr |=> (crc == CRC_SEED));
endmodule

// File: rtl/fb_byte_sel.sv
module fb_byte_sel
    import fb_pkg::*;
(
    input  frame_cfg_t         cfg,
    input  logic [POS_W-1:0]   pos,
    input  logic [15:0]        crc_fin,
    output logic [7:0]         data,
    output seg_e               seg,
    output logic               crc_feed,
    output logic               last
);
    localparam int SUM_W = POS_W + 1;

    logic [SUM_W-1:0] body_idx;
    logic [SUM_W-1:0] body_len;
    logic [SUM_W-1:0] pay_idx;
    logic [SUM_W-1:0] addr_sel;
    logic [7:0]       raw;

    always_comb begin
        body_idx = SUM_W'(pos) - SUM_W'(HDR_BYTES);
        body_len = SUM_W'(cfg.alen) + SUM_W'(cfg.plen);
        pay_idx  = body_idx - SUM_W'(cfg.alen);
        addr_sel = SUM_W'(cfg.alen) - 1'b1 - body_idx;
        raw      = 8'h00;
        data     = 8'h00;
        crc_feed = 1'b0;
        last     = 1'b0;
        if (pos == '0) begin
            seg  = SEG_LEN;
            data = 8'(body_len + SUM_W'(CRC_BYTES + 3));
        end else if (SUM_W'(pos) < SUM_W'(HDR_BYTES)) begin
            seg = SEG_PRE;
            case (pos[1:0])
                2'd1:    data = PRE0;
                2'd2:    data = PRE1;
                default: data = PRE2;
            endcase
        end else if (body_idx < SUM_W'(cfg.alen)) begin
            seg      = SEG_ADDR;
            raw      = 8'(cfg.addr >> (addr_sel * 8));
            data     = raw ^ whiten(5'(body_idx));
            crc_feed = !((cfg.alen == ALEN_W'(ADDR_MIN)) && (body_idx == '0));
        end else if (body_idx < body_len) begin
            seg      = SEG_PAY;
            raw      = 8'(cfg.pay >> (pay_idx * 8));
            data     = bitrev8(raw) ^ whiten(5'(body_idx));
            crc_feed = 1'b1;
        end else if (body_idx == body_len) begin
            seg  = SEG_CRC_HI;
            data = crc_fin[15:8];
        end else begin
            seg  = SEG_CRC_LO;
            data = crc_fin[7:0];
            last = 1'b1;
        end
    end
endmodule

// File: rtl/frame_builder.sv
module frame_builder
    import fb_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [2:0]   addr_len_req,
    input  logic [39:0]  addr_in,
    input  logic [4:0]   pay_len_req,
    input  logic [127:0] pay_in,
    output logic [7:0]   out_data,
    output logic         out_valid,
    input  logic         out_ready,
    output logic         out_last,
    output logic         busy
);
    state_e           state;
    frame_cfg_t       cfg;
    logic [POS_W-1:0] pos;
    logic             fire;
    logic             take;
    logic             crc_feed;
    logic [15:0]      crc_q;
    logic [15:0]      crc_fin;
    logic [7:0]       sel_data;
    logic             sel_last;
    seg_e             seg;

    assign busy      = (state == ST_SEND);
    assign out_valid = busy;
    assign fire      = out_valid && out_ready;
    assign take      = start && (state == ST_IDLE);
    assign out_data  = busy ? sel_data : 8'h00;
    assign out_last  = busy && sel_last;
    assign crc_fin   = crc_q ^ crc_xorout(5'(cfg.alen) - 5'd3 + 5'(cfg.plen));

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            pos   <= '0;
            cfg   <= '0;
        end else if (take) begin
            state    <= ST_SEND;
            pos      <= '0;
            cfg.alen <= clamp_alen(addr_len_req);
            cfg.plen <= clamp_plen(pay_len_req);
            cfg.addr <= addr_in;
            cfg.pay  <= pay_in;
        end else if (fire) begin
            if (sel_last) state <= ST_IDLE;
            else          pos   <= pos + 1'b1;
        end
    end

    fb_crc u_crc (
        .clk (clk),
        .rst (rst),
        .clr (take),
        .en  (fire && crc_feed),
        .din (sel_data),
        .crc (crc_q)
    );

    fb_byte_sel u_sel (
        .cfg      (cfg),
        .pos      (pos),
        .crc_fin  (crc_fin),
        .data     (sel_data),
        .seg      (seg),
        .crc_feed (crc_feed),
        .last     (sel_last)
    );

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));
    p_last_ends_r9: assert property (@(posedge clk) disable iff (rst)
        (fire && out_last) |=> !busy);
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && !out_ready) |=> $stable(pos));
    p_alen_range_r2: assert property (@(posedge clk) disable iff (rst)
        busy |-> (cfg.alen >= ALEN_W'(ADDR_MIN) && cfg.alen <= ALEN_W'(ADDR_MAX)));
    p_first_len_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (seg == SEG_LEN && out_data >= 8'd8));
    p_reset_idle_r1: assert property (@(posedge clk)
        $past(rst) |-> !busy);
endmodule

// File: tb/sim_frame_builder.sv
module sim_frame_builder;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [2:0]   alen;
        logic [4:0]   plen;
        logic [39:0]  addr;
        logic [127:0] pay;
        logic         stall;
    } vec_t;

    localparam int NVEC = 6;
    localparam vec_t VEC [NVEC] = '{
        '{3'd5, 5'd16, 40'h1122334455, 128'h00112233445566778899AABBCCDDEEFF, 1'b0},
        '{3'd3, 5'd4,  40'h00A1B2C3D4, 128'hDEADBEEF, 1'b1},
        '{3'd4, 5'd0,  40'h0F0E0D0C0B, 128'h0, 1'b0},
        '{3'd1, 5'd1,  40'h7766554433, 128'h5A, 1'b1},
        '{3'd7, 5'd20, 40'hCAFEBABE01, 128'hFEDCBA98765432100123456789ABCDEF, 1'b1},
        '{3'd0, 5'd16, 40'h0000000000, 128'hFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFFF, 1'b0}
    };

    localparam logic [7:0] WT [24] = '{
        8'hE3, 8'hB1, 8'h4B, 8'hEA, 8'h85, 8'hBC, 8'hE5, 8'h66,
        8'h0D, 8'hAE, 8'h8C, 8'h88, 8'h12, 8'h69, 8'hEE, 8'h1F,
        8'hC7, 8'h62, 8'h97, 8'hD5, 8'h0B, 8'h79, 8'hCA, 8'hCC};

    logic         clk = 0;
    logic         rst = 1;
    logic         start = 0;
    logic [2:0]   addr_len_req = 0;
    logic [39:0]  addr_in = 0;
    logic [4:0]   pay_len_req = 0;
    logic [127:0] pay_in = 0;
    logic [7:0]   out_data;
    logic         out_valid;
    logic         out_ready = 0;
    logic         out_last;
    logic         busy;

    int total = 0;
    int bad = 0;
    logic [7:0] exp_b [32];
    int exp_n;
    int exp_a;
    int exp_p;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_builder u0 (
        .clk(clk), .rst(rst), .start(start), .addr_len_req(addr_len_req),
        .addr_in(addr_in), .pay_len_req(pay_len_req), .pay_in(pay_in),
        .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_last(out_last), .busy(busy));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        total++;
        if (act !== expv) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[15] ^ d[i]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    task automatic build_model(input vec_t v);
        logic [15:0] c;
        logic [7:0]  b;
        logic [7:0]  rv;
        int          j;
        exp_a = (v.alen < 3) ? 3 : (v.alen > 5) ? 5 : int'(v.alen);
        exp_p = (v.plen > 16) ? 16 : int'(v.plen);
        exp_b[0] = 8'(exp_a + exp_p + 5);
        exp_b[1] = 8'h71; exp_b[2] = 8'h0F; exp_b[3] = 8'h55;
        c = 16'hB5D2;
        j = 0;
        for (int k = exp_a - 1; k >= 0; k--) begin
            b = v.addr[8*k +: 8] ^ WT[j];
            exp_b[4+j] = b;
            if (!(exp_a == 3 && j == 0)) c = m_crc(c, b);
            j++;
        end
        for (int i = 0; i < exp_p; i++) begin
            for (int q = 0; q < 8; q++) rv[q] = v.pay[8*i + 7 - q];
            b = rv ^ WT[j];
            exp_b[4+j] = b;
            c = m_crc(c, b);
            j++;
        end
        c = c ^ {WT[exp_a - 3 + exp_p], WT[exp_a - 2 + exp_p]};
        exp_b[4+j] = c[15:8];
        exp_b[5+j] = c[7:0];
        exp_n = 6 + j;
    endtask

    function automatic string tag_of(input int k);
        if (k == 0) return "R3 length";
        if (k < 4) return "R3 preamble";
        if (k < 4 + exp_a) return "R4 address";
        if (k < 4 + exp_a + exp_p) return "R5 payload";
        return "R6/R7 crc";
    endfunction

    task automatic apply(input vec_t v);
        @(negedge clk);
        addr_len_req = v.alen; pay_len_req = v.plen;
        addr_in = v.addr; pay_in = v.pay;
        start = 1;
        @(negedge clk);
        start = 0;
        check("R9 busy after start", busy, 1);
    endtask

    task automatic drain(input logic stall, input int inject_at, input vec_t other);
        int k = 0;
        int cyc = 0;
        while (k < exp_n) begin
            check("R9 valid", out_valid, 1);
            check(tag_of(k), out_data, exp_b[k]);
            check("R7 last flag", out_last, (k == exp_n - 1));
            out_ready = !(stall && (cyc % 3 == 1));
            if (k == inject_at && inject_at >= 0) begin
                start = 1; addr_len_req = other.alen; pay_len_req = other.plen;
                addr_in = other.addr; pay_in = other.pay;
            end else start = 0;
            if (out_ready) k++;
            cyc++;
            @(negedge clk);
        end
        start = 0;
        out_ready = 0;
        check("R9 busy cleared", busy, 0);
        check("R9 valid cleared", out_valid, 0);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R1 busy", busy, 0);
        check("R1 valid", out_valid, 0);
        check("R1 last", out_last, 0);

        for (int n = 0; n < NVEC; n++) begin
            build_model(VEC[n]);
            apply(VEC[n]);
            drain(VEC[n].stall, -1, VEC[n]);
        end

        // R2 clamp seen in length byte: request 2 -> 3, 6 -> 5, payload 31 -> 16
        build_model('{3'd2, 5'd31, 40'h0102030405, 128'h1, 1'b0});
        check("R2 alen clamp low", exp_a, 3);
        apply('{3'd2, 5'd31, 40'h0102030405, 128'h1, 1'b0});
        check("R2 length byte", out_data, 8'd24);
        drain(1'b0, -1, VEC[0]);
        build_model('{3'd6, 5'd2, 40'h0102030405, 128'h1234, 1'b1});
        apply('{3'd6, 5'd2, 40'h0102030405, 128'h1234, 1'b1});
        check("R2 alen clamp high", out_data, 8'd12);
        drain(1'b1, -1, VEC[0]);

        // R10: start with other inputs mid-frame is ignored
        build_model(VEC[1]);
        apply(VEC[1]);
        drain(1'b1, 5, VEC[4]);

        // R8: long stall holds the byte
        build_model(VEC[2]);
        apply(VEC[2]);
        out_ready = 0;
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            check("R8 hold during stall", out_data, exp_b[0]);
        end
        drain(1'b0, -1, VEC[0]);

        // R1: reset during a frame returns to idle
        build_model(VEC[0]);
        apply(VEC[0]);
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1 busy after mid-frame reset", busy, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule